// File: doc/BRIEF.md
# Qualified Lock Gate for a Clock Synthesizer

A clock synthesizer reports lock on a raw flag that changes with no relation to any clock in the logic that reads it. This block turns that flag into a lock status that downstream logic can trust. The flag is first carried into the reference clock domain through a two-stage flop chain. A counter then measures how long it has stayed high. The qualified lock output rises only once the flag has been high for a hold-off count of reference cycles. That count is the longest lock time the synthesizer may need, divided by the reference period and rounded up.

A single low sample of the synchronized flag drops the qualified lock at once and restarts the count from zero. When automatic recovery is enabled, the loss of a qualified lock also sends a reset request of fixed length back to the synthesizer. The count is held at zero for as long as that request lasts, so lock must be earned again in full after the synthesizer restarts.

A vector of output clock enables follows the qualified lock. The enables open one cycle after qualification and close in the same cycle that the qualified lock drops. An asynchronous, active-high user reset clears every flop and forces all enables low. All pins are plain control and status lines, so the block has no stream interface and no back-pressure.

Top module: `lock_qualifier`

## Requirements
- R1: While `user_rst` is high, `qual_lock`, `pll_rst_req` and every bit of `out_clk_en` are 0. The reset acts without waiting for a clock edge, and it clears any lock that was already qualified.
- R2: `raw_lock` reaches the hold-off counter through two `ref_clk` flops. A change of `raw_lock` made between two edges therefore first affects `qual_lock` after the second following rising edge.
- R3: The hold-off count is HOLD = ceil(LOCK_TIME_PS / REF_PERIOD_PS), which is 16 with the default parameters. After `raw_lock` rises, `qual_lock` stays 0 through the first 1+HOLD rising edges and is 1 after edge 2+HOLD.
- R4: Once asserted, `qual_lock` stays 1 for as long as `raw_lock` stays 1.
- R5: A synchronized low sample, even one cycle long, drops `qual_lock` in that same cycle and clears the count. A later return to high needs the full HOLD cycles again.
- R6: A `raw_lock` high period shorter than HOLD cycles never asserts `qual_lock`.
- R7: With `auto_rst_en` = 1, the loss of a qualified lock raises `pll_rst_req` one cycle after `qual_lock` falls. The request stays high for exactly RST_CYCLES cycles (default 4), and only one request is issued per loss event, even if `raw_lock` stays low.
- R8: With `auto_rst_en` = 0, a loss of lock never raises `pll_rst_req`.
- R9: A low `raw_lock` that was never qualified does not raise `pll_rst_req`.
- R10: While `pll_rst_req` is high, the count is held at zero. `qual_lock` rises only after HOLD further rising edges with the synchronized flag high, counted from the first edge after the request ends.
- R11: All NUM_OUTS bits of `out_clk_en` rise together one cycle after `qual_lock` rises, and fall in the same cycle that `qual_lock` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that runs the synchronizer and the counters |
| user_rst | input | 1 | Asynchronous active-high reset |
| raw_lock | input | 1 | Unsynchronized lock flag from the synthesizer |
| auto_rst_en | input | 1 | When 1, a loss of qualified lock requests a synthesizer reset |
| qual_lock | output | 1 | Qualified lock status |
| pll_rst_req | output | 1 | Reset request pulse to the synthesizer |
| out_clk_en | output | NUM_OUTS | Enables for the synthesizer's output clocks |

## Verification
A clean rise of the lock flag is held for a long time. This pins the qualification edge to the exact cycle, which separates an off-by-one in the count or in the synchronizer depth from a correct design, and it also shows that a held lock never drops. A one-cycle dropout is applied with automatic recovery off and again with it on. The first run shows a restart of the count with no request. The second shows a single request of the right length, and that qualification starts again only after the request ends. A sustained loss, a short high period that never qualifies, a loss before qualification, and a reset applied between clock edges cover the repeat-pulse, never-qualified and asynchronous-clear cases.

// File: rtl/lock_qual_pkg.sv
package lock_qual_pkg;

  // Round-up integer division used to turn a lock time into cycles.
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '0;
    else      chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lock_hold_counter.sv
module lock_hold_counter #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic sync_lock,
  input  logic hold_clr,
  output logic qual_lock
);

  localparam int unsigned CNT_W = $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                        cnt <= '0;
    else if (!sync_lock || hold_clr) cnt <= '0;
    else if (cnt != HOLD_C)          cnt <= cnt + 1'b1;
  end

  assign qual_lock = sync_lock && !hold_clr && (cnt == HOLD_C);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (arst)
    cnt <= HOLD_C);

  // R5
  low_clears_chk: assert property (@(posedge clk) disable iff (arst)
    !sync_lock |=> (cnt == '0));

  // R10
  clr_holds_chk: assert property (@(posedge clk) disable iff (arst)
    hold_clr |=> !qual_lock);

endmodule

// File: rtl/lock_auto_reset.sv
module lock_auto_reset #(
  parameter int unsigned PULSE = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic enable,
  input  logic qual_lock,
  output logic rst_req
);

  localparam int unsigned PW = $clog2(PULSE + 1);
  localparam logic [PW-1:0] PULSE_C = PW'(PULSE);

  logic          qual_d;
  logic          lost;
  logic [PW-1:0] left;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) qual_d <= 1'b0;
    else      qual_d <= qual_lock;
  end

  assign lost = qual_d && !qual_lock;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                left <= '0;
    else if (lost && enable) left <= PULSE_C;
    else if (left != '0)     left <= left - 1'b1;
  end

  assign rst_req = (left != '0);

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (arst)
    rst_req |-> !qual_lock);

  // R8
  no_req_when_off_chk: assert property (@(posedge clk) disable iff (arst)
    (!enable && !rst_req) |=> !rst_req);

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import lock_qual_pkg::*;
#(
  parameter int unsigned LOCK_TIME_PS  = 80000,
  parameter int unsigned REF_PERIOD_PS = 5000,
  parameter int unsigned RST_CYCLES    = 4,
  parameter int unsigned NUM_OUTS      = 3,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                ref_clk,
  input  logic                user_rst,
  input  logic                raw_lock,
  input  logic                auto_rst_en,
  output logic                qual_lock,
  output logic                pll_rst_req,
  output logic [NUM_OUTS-1:0] out_clk_en
);

  localparam int unsigned HOLD = ceil_div(LOCK_TIME_PS, REF_PERIOD_PS);

  logic sync_lock;

  lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (ref_clk),
    .arst (user_rst),
    .d    (raw_lock),
    .q    (sync_lock)
  );

  lock_hold_counter #(.HOLD(HOLD)) u_hold (
    .clk       (ref_clk),
    .arst      (user_rst),
    .sync_lock (sync_lock),
    .hold_clr  (pll_rst_req),
    .qual_lock (qual_lock)
  );

  lock_auto_reset #(.PULSE(RST_CYCLES)) u_arst (
    .clk       (ref_clk),
    .arst      (user_rst),
    .enable    (auto_rst_en),
    .qual_lock (qual_lock),
    .rst_req   (pll_rst_req)
  );

  // One arming flop per output: opens a cycle after qualification,
  // closes combinationally with the qualified lock.
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_en
    logic armed;
    always_ff @(posedge ref_clk or posedge user_rst) begin
      if (user_rst) armed <= 1'b0;
      else          armed <= qual_lock;
    end
    assign out_clk_en[i] = armed && qual_lock;
  end

  // R11
  en_follows_qual_chk: assert property (@(posedge ref_clk) disable iff (user_rst)
    (|out_clk_en) |-> qual_lock);

  // R3
  rise_after_sync_chk: assert property (@(posedge ref_clk) disable iff (user_rst)
    $rose(qual_lock) |-> $past(sync_lock));

endmodule

// File: tb/lock_qualifier_bench.sv
`timescale 1ns/1ps
module lock_qualifier_bench;

  localparam int unsigned LOCK_PS = 80000;
  localparam int unsigned REF_PS  = 5000;
  localparam int unsigned NRST    = 4;
  localparam int unsigned OUTS    = 3;
  localparam int unsigned HOLD    = (LOCK_PS + REF_PS - 1) / REF_PS;

  logic ref_clk = 1'b0;
  logic user_rst = 1'b1;
  logic raw_lock = 1'b0;
  logic auto_rst_en = 1'b0;
  logic qual_lock;
  logic pll_rst_req;
  logic [OUTS-1:0] out_clk_en;

  int checks = 0;
  int errors = 0;

  always #2.5 ref_clk = ~ref_clk;

  lock_qualifier #(
    .LOCK_TIME_PS(LOCK_PS), .REF_PERIOD_PS(REF_PS),
    .RST_CYCLES(NRST), .NUM_OUTS(OUTS), .SYNC_STAGES(2)
  ) u_lock_qualifier (
    .ref_clk(ref_clk), .user_rst(user_rst), .raw_lock(raw_lock),
    .auto_rst_en(auto_rst_en), .qual_lock(qual_lock),
    .pll_rst_req(pll_rst_req), .out_clk_en(out_clk_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic settle();
    raw_lock = 1'b0;
    user_rst = 1'b1;
    tick(2);
    user_rst = 1'b0;
    tick(1);
  endtask

  task automatic acquire();
    raw_lock = 1'b1;
    tick(2 + HOLD);
  endtask

  task automatic t_reset();
    raw_lock = 1'b1;
    user_rst = 1'b1;
    tick(4);
    check(qual_lock == 0 && pll_rst_req == 0 && out_clk_en == 0, "R1 outputs in reset",
          {qual_lock, pll_rst_req, out_clk_en}, 0);
    settle();
  endtask

  task automatic t_qualify();
    raw_lock = 1'b1;
    tick(1 + HOLD);
    check(qual_lock == 0, "R2/R3 low one edge early", qual_lock, 0);
    tick(1);
    check(qual_lock == 1, "R3 qualified after 2+HOLD edges", qual_lock, 1);
    check(out_clk_en == 0, "R11 enables wait a cycle", out_clk_en, 0);
    tick(1);
    check(out_clk_en == {OUTS{1'b1}}, "R11 enables open", out_clk_en, {OUTS{1'b1}});
    begin
      int drops = 0;
      for (int i = 0; i < 60; i++) begin tick(1); if (!qual_lock) drops++; end
      check(drops == 0, "R4 held while raw high", drops, 0);
    end
    raw_lock = 1'b0;
    tick(1);
    check(qual_lock == 1, "R2 drop not seen after one edge", qual_lock, 1);
    tick(1);
    check(qual_lock == 0, "R5 drop after two edges", qual_lock, 0);
    check(out_clk_en == 0, "R11 enables close with lock", out_clk_en, 0);
    tick(4);
    settle();
  endtask

  task automatic t_short();
    int highs = 0;
    raw_lock = 1'b1;
    tick(HOLD - 1);
    raw_lock = 1'b0;
    for (int i = 0; i < 2 * HOLD; i++) begin tick(1); if (qual_lock) highs++; end
    check(highs == 0, "R6 short high never qualifies", highs, 0);
    settle();
  endtask

  task automatic t_glitch(input bit en);
    int reqs = 0;
    int rises = 0;
    bit prev = 0;
    int base;
    auto_rst_en = en;
    acquire();
    check(qual_lock == 1, "R3 qualified before glitch", qual_lock, 1);
    base = en ? NRST : 0;
    raw_lock = 1'b0;
    for (int i = 1; i <= 4 + base + HOLD; i++) begin
      tick(1);
      if (i == 1) raw_lock = 1'b1;
      if (pll_rst_req) reqs++;
      if (pll_rst_req && !prev) rises++;
      prev = pll_rst_req;
      if (i == 2) check(qual_lock == 0, "R5 one-cycle glitch drops lock", qual_lock, 0);
      if (en && i == 2) check(pll_rst_req == 0, "R7 request not before next cycle", pll_rst_req, 0);
      if (en && i == 3) check(pll_rst_req == 1, "R7 request one cycle after loss", pll_rst_req, 1);
      if (en && i == 3 + NRST) check(pll_rst_req == 0, "R7 request ended", pll_rst_req, 0);
      if (i == 2 + base + HOLD) check(qual_lock == 0, en ? "R10 no early relock" : "R5 full recount", qual_lock, 0);
      if (i == 3 + base + HOLD) check(qual_lock == 1, en ? "R10 relock after request" : "R5 relock", qual_lock, 1);
    end
    if (en) begin
      check(reqs == NRST, "R7 request length", reqs, NRST);
      check(rises == 1, "R7 single request", rises, 1);
    end else begin
      check(reqs == 0, "R8 no request when disabled", reqs, 0);
    end
    auto_rst_en = 1'b0;
    settle();
  endtask

  task automatic t_sustained();
    int rises = 0;
    bit prev = 0;
    auto_rst_en = 1'b1;
    acquire();
    raw_lock = 1'b0;
    for (int i = 0; i < 6 * NRST + 10; i++) begin
      tick(1);
      if (pll_rst_req && !prev) rises++;
      prev = pll_rst_req;
    end
    check(rises == 1, "R7 one request per sustained loss", rises, 1);
    auto_rst_en = 1'b0;
    settle();
  endtask

  task automatic t_unqualified();
    int reqs = 0;
    auto_rst_en = 1'b1;
    raw_lock = 1'b1;
    tick(HOLD / 2);
    raw_lock = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(1); if (pll_rst_req) reqs++; end
    check(reqs == 0, "R9 no request without prior lock", reqs, 0);
    auto_rst_en = 1'b0;
    settle();
  endtask

  task automatic t_async_reset();
    acquire();
    tick(2);
    check(out_clk_en == {OUTS{1'b1}}, "R11 enables open before reset", out_clk_en, {OUTS{1'b1}});
    #1 user_rst = 1'b1;
    #0.5;
    check(qual_lock == 0, "R1 reset clears lock without edge", qual_lock, 0);
    check(out_clk_en == 0, "R1 reset closes enables", out_clk_en, 0);
    @(negedge ref_clk);
    user_rst = 1'b0;
    tick(1 + HOLD);
    check(qual_lock == 0, "R1 full count after reset", qual_lock, 0);
    tick(1);
    check(qual_lock == 1, "R3 requalified after reset", qual_lock, 1);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge ref_clk);
    t_reset();
    t_qualify();
    t_short();
    t_glitch(1'b0);
    t_glitch(1'b1);
    t_sustained();
    t_unqualified();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule